// File: doc/BRIEF.md
# Serial Port Interrupt Flag Router

This block sits between the status logic of a UART-style serial port and the processor's interrupt controller. It gathers the individual receive error flags (break, framing, overrun, parity), the receive-ready and transmit-ready flags, and the word counts of the receive and transmit queues. From these it produces one receive interrupt line and one transmit interrupt line. The sources it routes, and the enable bits that gate them, depend on a single queued-mode switch.

The four receive error flags are merged into a composite error flag. This flag is sticky: it stays set until software applies a clear pulse. With queueing off, the receive line carries the composite error, the raw break flag and the receive-ready flag. The transmit line carries transmit-ready. With queueing on, break reaches the receive line only through the composite error. Receive-ready and transmit-ready are replaced by two threshold comparisons: the receive word count against a programmable level, and the transmit word count against a second level. Both interrupt lines are registered, so the processor sees a clean level that has no combinational glitches.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `sirq_router`

## Requirements
- R1: The composite error flag `rx_err_flag` is set on the clock edge after any of `brk_det`, `frame_err`, `overrun_err` or `parity_err` is high.
- R2: Once set, `rx_err_flag` holds until a cycle in which `err_clr` is high and all four error sources are low. It then reads 0 after the next edge. A clear pulse is overridden by any error source that is high in the same cycle.
- R3: With `q_en` low, `rx_irq` after an edge equals (`en_rx_err` AND `rx_err_flag`) OR (`en_rx_brk` AND (`brk_det` OR `rx_ready`)), with all terms sampled at that edge.
- R4: With `q_en` low, `tx_irq` after an edge equals `en_tx` AND `tx_ready` sampled at that edge.
- R5: With `q_en` high, `rx_irq` after an edge equals (`en_rx_err` AND `rx_err_flag`) OR (`en_rxq` AND `rx_cnt` >= receive level). `brk_det`, `rx_ready` and `en_rx_brk` then have no direct effect on `rx_irq`.
- R6: With `q_en` high, `tx_irq` after an edge equals `en_txq` AND `tx_cnt` <= transmit level. `tx_ready` and `en_tx` then have no effect.
- R7: The receive level resets to all ones (31 for the default 5-bit width). The transmit level resets to 0. A cycle with `rx_lvl_wr` or `tx_lvl_wr` high loads `rx_lvl_in` or `tx_lvl_in`, and the new level governs comparisons from the next edge on.
- R8: While `rst_n` is low, `rx_irq`, `tx_irq` and `rx_err_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_en | input | 1 | Queued-mode switch |
| brk_det | input | 1 | Break detected |
| frame_err | input | 1 | Framing error |
| overrun_err | input | 1 | Overrun error |
| parity_err | input | 1 | Parity error |
| err_clr | input | 1 | Clear pulse for the composite error flag |
| rx_ready | input | 1 | Received word ready (non-queued) |
| tx_ready | input | 1 | Transmitter ready (non-queued) |
| rx_cnt | input | CNT_W | Words held in the receive queue |
| tx_cnt | input | CNT_W | Words held in the transmit queue |
| rx_lvl_wr | input | 1 | Load strobe for the receive level |
| rx_lvl_in | input | CNT_W | New receive level |
| tx_lvl_wr | input | 1 | Load strobe for the transmit level |
| tx_lvl_in | input | CNT_W | New transmit level |
| en_rx_err | input | 1 | Enable for the composite error path |
| en_rx_brk | input | 1 | Enable for the break/ready path (non-queued) |
| en_tx | input | 1 | Enable for transmit-ready (non-queued) |
| en_rxq | input | 1 | Enable for the receive threshold (queued) |
| en_txq | input | 1 | Enable for the transmit threshold (queued) |
| rx_irq | output | 1 | Registered receive interrupt |
| tx_irq | output | 1 | Registered transmit interrupt |
| rx_err_flag | output | 1 | Sticky composite receive error |

## Verification
The bench builds the block with the default `CNT_W` of 5. This lets counts and levels span the whole 0 to 31 range. The bench can therefore drive the receive count to exactly the reset level of all ones, and to one below it, and find the edge of the "inactive by default" threshold. Equal-count boundaries are checked after level writes at both ends, and the transmit condition is checked at its reset level of zero. Random mode switches mid-stream exercise the moments when the routing changes while a sticky error is pending.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic {
    CMP_AT_LEAST = 1'b0,
    CMP_AT_MOST  = 1'b1
  } cmp_dir_e;

  typedef struct packed {
    logic brk;
    logic frame;
    logic overrun;
    logic parity;
  } rx_err_t;

  localparam int unsigned NUM_RX_ERR = $bits(rx_err_t);

  typedef struct packed {
    logic en_rx_err;
    logic en_rx_brk;
    logic en_tx;
    logic en_rxq;
    logic en_txq;
  } irq_en_t;

endpackage

// File: rtl/sirq_err_latch.sv
module sirq_err_latch #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr,
  output logic               flag
);

  logic [NUM_SRC-1:0] chain;
  logic               any_src;
  logic               flag_q;

  // OR chain built per source so the width follows the parameter.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_or
      if (gi == 0) begin : g_first
        assign chain[gi] = src[gi];
      end else begin : g_next
        assign chain[gi] = chain[gi-1] | src[gi];
      end
    end
  endgenerate

  assign any_src = chain[NUM_SRC-1];

  // A source active in the clear cycle wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q & ~clr) | any_src;
  end

  assign flag = flag_q;

endmodule

// File: rtl/sirq_thresh.sv
module sirq_thresh
  import sirq_pkg::*;
#(
  parameter int unsigned       CNT_W   = 5,
  parameter cmp_dir_e          DIR     = CMP_AT_LEAST,
  parameter logic [CNT_W-1:0]  RST_LVL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_wr,
  input  logic [CNT_W-1:0] lvl_in,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= RST_LVL;
    else if (lvl_wr) lvl_q <= lvl_in;
  end

  generate
    if (DIR == CMP_AT_LEAST) begin : g_ge
      assign hit = (cnt >= lvl_q);
    end else begin : g_le
      assign hit = (cnt <= lvl_q);
    end
  endgenerate

endmodule

// File: rtl/sirq_route.sv
module sirq_route
  import sirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    q_en,
  input  irq_en_t en,
  input  logic    err_flag,
  input  logic    brk,
  input  logic    rx_ready,
  input  logic    tx_ready,
  input  logic    rx_hit,
  input  logic    tx_hit,
  output logic    rx_irq,
  output logic    tx_irq
);

  logic err_term;
  logic rx_direct;
  logic rx_queued;
  logic rx_next;
  logic tx_next;
  logic rx_q;
  logic tx_q;

  // The composite error path is common to both modes.
  assign err_term  = en.en_rx_err & err_flag;
  // Raw break reaches the line only when queueing is off.
  assign rx_direct = en.en_rx_brk & (brk | rx_ready);
  assign rx_queued = en.en_rxq & rx_hit;

  always_comb begin
    if (q_en) begin
      rx_next = err_term | rx_queued;
      tx_next = en.en_txq & tx_hit;
    end else begin
      rx_next = err_term | rx_direct;
      tx_next = en.en_tx & tx_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_next;
      tx_q <= tx_next;
    end
  end

  assign rx_irq = rx_q;
  assign tx_irq = tx_q;

endmodule

// File: rtl/sirq_router.sv
module sirq_router
  import sirq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_en,
  input  logic             brk_det,
  input  logic             frame_err,
  input  logic             overrun_err,
  input  logic             parity_err,
  input  logic             err_clr,
  input  logic             rx_ready,
  input  logic             tx_ready,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             rx_lvl_wr,
  input  logic [CNT_W-1:0] rx_lvl_in,
  input  logic             tx_lvl_wr,
  input  logic [CNT_W-1:0] tx_lvl_in,
  input  logic             en_rx_err,
  input  logic             en_rx_brk,
  input  logic             en_tx,
  input  logic             en_rxq,
  input  logic             en_txq,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             rx_err_flag
);

  localparam logic [CNT_W-1:0] RX_LVL_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TX_LVL_RST = '0;

  rx_err_t errs;
  irq_en_t ens;
  logic    err_flag;
  logic    rx_hit;
  logic    tx_hit;

  assign errs = '{brk: brk_det, frame: frame_err, overrun: overrun_err, parity: parity_err};
  assign ens  = '{en_rx_err: en_rx_err, en_rx_brk: en_rx_brk, en_tx: en_tx,
                  en_rxq: en_rxq, en_txq: en_txq};

  sirq_err_latch #(
    .NUM_SRC (NUM_RX_ERR)
  ) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (errs),
    .clr   (err_clr),
    .flag  (err_flag)
  );

  sirq_thresh #(
    .CNT_W   (CNT_W),
    .DIR     (CMP_AT_LEAST),
    .RST_LVL (RX_LVL_RST)
  ) u_rx_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_wr (rx_lvl_wr),
    .lvl_in (rx_lvl_in),
    .cnt    (rx_cnt),
    .hit    (rx_hit)
  );

  sirq_thresh #(
    .CNT_W   (CNT_W),
    .DIR     (CMP_AT_MOST),
    .RST_LVL (TX_LVL_RST)
  ) u_tx_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_wr (tx_lvl_wr),
    .lvl_in (tx_lvl_in),
    .cnt    (tx_cnt),
    .hit    (tx_hit)
  );

  sirq_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_en     (q_en),
    .en       (ens),
    .err_flag (err_flag),
    .brk      (brk_det),
    .rx_ready (rx_ready),
    .tx_ready (tx_ready),
    .rx_hit   (rx_hit),
    .tx_hit   (tx_hit),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq)
  );

  assign rx_err_flag = err_flag;

endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk (
  input logic clk,
  input logic rst_n,
  input logic q_en,
  input logic brk_det,
  input logic frame_err,
  input logic overrun_err,
  input logic parity_err,
  input logic err_clr,
  input logic rx_ready,
  input logic tx_ready,
  input logic en_rx_err,
  input logic en_rx_brk,
  input logic en_tx,
  input logic en_rxq,
  input logic en_txq,
  input logic rx_irq,
  input logic tx_irq,
  input logic rx_err_flag
);

  logic any_err;
  assign any_err = brk_det | frame_err | overrun_err | parity_err;

  a_r1_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> rx_err_flag);

  a_r2_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_flag && !err_clr) |=> rx_err_flag);

  a_r2_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !any_err) |=> !rx_err_flag);

  a_r3_ready_routes: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && en_rx_brk && rx_ready) |=> rx_irq);

  a_r3_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && !en_rx_brk && !en_rx_err) |=> !rx_irq);

  a_r4_tx_routes: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && en_tx && tx_ready) |=> tx_irq);

  a_r4_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && !en_tx) |=> !tx_irq);

  a_r5_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && !en_rx_err && !en_rxq) |=> !rx_irq);

  a_r6_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && !en_txq) |=> !tx_irq);

  // R8: outputs held low during reset
  always_comb begin
    if (!rst_n) begin
      a_r8_reset_low: assert (!rx_irq && !tx_irq && !rx_err_flag);
    end
  end

endmodule

bind sirq_router sirq_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .q_en        (q_en),
  .brk_det     (brk_det),
  .frame_err   (frame_err),
  .overrun_err (overrun_err),
  .parity_err  (parity_err),
  .err_clr     (err_clr),
  .rx_ready    (rx_ready),
  .tx_ready    (tx_ready),
  .en_rx_err   (en_rx_err),
  .en_rx_brk   (en_rx_brk),
  .en_tx       (en_tx),
  .en_rxq      (en_rxq),
  .en_txq      (en_txq),
  .rx_irq      (rx_irq),
  .tx_irq      (tx_irq),
  .rx_err_flag (rx_err_flag)
);

// File: tb/sirq_router_tb_top.sv
module sirq_router_tb_top;

  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_en = 0, brk_det = 0, frame_err = 0, overrun_err = 0, parity_err = 0;
  logic err_clr = 0, rx_ready = 0, tx_ready = 0;
  logic [CW-1:0] rx_cnt = '0, tx_cnt = '0, rx_lvl_in = '0, tx_lvl_in = '0;
  logic rx_lvl_wr = 0, tx_lvl_wr = 0;
  logic en_rx_err = 0, en_rx_brk = 0, en_tx = 0, en_rxq = 0, en_txq = 0;
  logic rx_irq, tx_irq, rx_err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sirq_router #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .brk_det(brk_det),
    .frame_err(frame_err), .overrun_err(overrun_err), .parity_err(parity_err),
    .err_clr(err_clr), .rx_ready(rx_ready), .tx_ready(tx_ready),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_lvl_wr(rx_lvl_wr), .rx_lvl_in(rx_lvl_in),
    .tx_lvl_wr(tx_lvl_wr), .tx_lvl_in(tx_lvl_in), .en_rx_err(en_rx_err),
    .en_rx_brk(en_rx_brk), .en_tx(en_tx), .en_rxq(en_rxq), .en_txq(en_txq),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_err_flag(rx_err_flag)
  );

  // Behavioural reference model, stepped on each rising edge.
  bit m_err = 0, m_rx = 0, m_tx = 0, m_q = 0;
  int m_rxl = 31, m_txl = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = 0; m_rx = 0; m_tx = 0; m_rxl = 31; m_txl = 0; m_q = 0;
    end else begin
      bit any, rh, th, nrx, ntx;
      any = brk_det || frame_err || overrun_err || parity_err;
      rh  = int'(rx_cnt) >= m_rxl;
      th  = int'(tx_cnt) <= m_txl;
      if (q_en) begin
        nrx = (en_rx_err && m_err) || (en_rxq && rh);
        ntx = en_txq && th;
      end else begin
        nrx = (en_rx_err && m_err) || (en_rx_brk && (brk_det || rx_ready));
        ntx = en_tx && tx_ready;
      end
      if (err_clr) m_err = 0;
      if (any) m_err = 1;
      if (rx_lvl_wr) m_rxl = int'(rx_lvl_in);
      if (tx_lvl_wr) m_txl = int'(tx_lvl_in);
      m_rx = nrx; m_tx = ntx; m_q = q_en;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1/R2 rx_err_flag vs model", rx_err_flag, m_err);
      chk(m_q ? "R5 rx_irq vs model" : "R3 rx_irq vs model", rx_irq, m_rx);
      chk(m_q ? "R6 tx_irq vs model" : "R4 tx_irq vs model", tx_irq, m_tx);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic tick_check(input string tag, input logic act_sel, input logic exp);
    // act_sel: 0 -> rx_irq, 1 -> tx_irq
    @(posedge clk); #1;
    chk(tag, act_sel ? tx_irq : rx_irq, exp);
    @(negedge clk);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 rx_irq in reset", rx_irq, 1'b0);
    chk("R8 tx_irq in reset", tx_irq, 1'b0);
    chk("R8 rx_err_flag in reset", rx_err_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: default receive level is all ones
    q_en = 1; en_rxq = 1; rx_cnt = 5'd30;
    tick_check("R7 rx below default level", 1'b0, 1'b0);
    rx_cnt = 5'd31;
    tick_check("R7 rx at default level", 1'b0, 1'b1);
    // R7: default transmit level is zero
    en_txq = 1; tx_cnt = 5'd0;
    tick_check("R7 tx at default level", 1'b1, 1'b1);
    tx_cnt = 5'd1;
    tick_check("R7 tx above default level", 1'b1, 1'b0);

    // R7: level writes
    rx_lvl_wr = 1; rx_lvl_in = 5'd4; tx_lvl_wr = 1; tx_lvl_in = 5'd6;
    @(negedge clk);
    rx_lvl_wr = 0; tx_lvl_wr = 0; rx_cnt = 5'd4; tx_cnt = 5'd6;
    tick_check("R7 rx equal to written level", 1'b0, 1'b1);
    rx_cnt = 5'd3; tx_cnt = 5'd7;
    tick_check("R7 rx below written level", 1'b0, 1'b0);
    chk("R7 tx above written level", tx_irq, 1'b0);

    // R5: in queued mode break and ready have no direct path
    en_rxq = 0; en_txq = 0; en_rx_err = 0; en_rx_brk = 1; brk_det = 1; rx_ready = 1;
    tx_ready = 1; en_tx = 1;
    tick_check("R5 break ignored in queued mode", 1'b0, 1'b0);
    chk("R6 tx_ready ignored in queued mode", tx_irq, 1'b0);
    chk("R1 break sets composite flag", rx_err_flag, 1'b1);
    brk_det = 0; rx_ready = 0;
    // R5: error reaches line through composite flag
    en_rx_err = 1;
    tick_check("R5 composite error routed", 1'b0, 1'b1);

    // R2: sticky, then cleared
    en_rx_err = 0;
    repeat (3) @(negedge clk);
    chk("R2 flag held without clear", rx_err_flag, 1'b1);
    err_clr = 1; overrun_err = 1;
    @(negedge clk);
    chk("R2 source overrides clear", rx_err_flag, 1'b1);
    overrun_err = 0;
    @(negedge clk);
    err_clr = 0;
    @(negedge clk);
    chk("R2 flag cleared", rx_err_flag, 1'b0);

    // R3/R4: non-queued routing
    q_en = 0; en_rx_brk = 1; rx_ready = 1;
    tick_check("R3 ready routed", 1'b0, 1'b1);
    chk("R4 tx_ready routed", tx_irq, 1'b1);
    rx_ready = 0; en_rx_brk = 0; en_rx_err = 1; parity_err = 1;
    @(negedge clk);
    parity_err = 0;
    tick_check("R3 parity error via composite two edges later", 1'b0, 1'b1);
    err_clr = 1; en_rx_err = 0; tx_ready = 0;
    @(negedge clk);
    err_clr = 0;

    // Random phase, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      q_en        = ($urandom_range(7) == 0) ? ~q_en : q_en;
      brk_det     = ($urandom_range(15) == 0);
      frame_err   = ($urandom_range(15) == 0);
      overrun_err = ($urandom_range(15) == 0);
      parity_err  = ($urandom_range(15) == 0);
      err_clr     = ($urandom_range(5) == 0);
      rx_ready    = $urandom_range(1) == 1;
      tx_ready    = $urandom_range(1) == 1;
      rx_cnt      = CW'($urandom_range(31));
      tx_cnt      = CW'($urandom_range(31));
      rx_lvl_wr   = ($urandom_range(20) == 0);
      tx_lvl_wr   = ($urandom_range(20) == 0);
      rx_lvl_in   = CW'($urandom_range(31));
      tx_lvl_in   = CW'($urandom_range(31));
      en_rx_err   = $urandom_range(1) == 1;
      en_rx_brk   = $urandom_range(1) == 1;
      en_tx       = $urandom_range(1) == 1;
      en_rxq      = $urandom_range(1) == 1;
      en_txq      = $urandom_range(1) == 1;
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule